// File: doc/BRIEF.md
# Integer Add Execute Stage with Status Flags

This block is the execute step for the legacy byte-coded integer add family. Operand values arrive already fetched: a register operand, a register-or-memory operand and an immediate field. A front end also supplies the opcode byte, the 3-bit reg field of the addressing byte and a size bit.

From the opcode the block works out three things: which value is the destination, which is the source, and whether the add is 8, 16 or 32 bits wide. A short immediate is sign-extended where the opcode calls for it. The block then forms the width-truncated sum and six status flags: carry, parity, half carry, zero, sign and overflow. It returns the sum, a code naming where the sum must be written back, and the flags.

Results are registered. They appear one clock edge after a start strobe. An opcode the block does not accept raises a separate error output and leaves the stored result and flags untouched. The write-back and the memory access are done by the caller.

Top module: `addx_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `resValid`, `invalidOp`, `result`, `destSel` and all six flag outputs are cleared to 0.
- R2: Opcode 0x04 adds an 8-bit immediate to the accumulator value given on `regVal`. Opcode 0x05 adds a 16-bit or 32-bit immediate to it. Both report `destSel` = 2 (accumulator).
- R3: Opcodes 0x80 and 0x81 with `modrmReg` = 0 add the immediate to `rmVal`, at 8 bits and at 16/32 bits respectively, with `destSel` = 0 (register-or-memory).
- R4: Opcode 0x83 with `modrmReg` = 0 sign-extends `immVal[7:0]` to the 16-bit or 32-bit width and adds it to `rmVal`, with `destSel` = 0.
- R5: Opcodes 0x00 and 0x01 compute `rmVal` + `regVal` with `destSel` = 0. Opcodes 0x02 and 0x03 compute `regVal` + `rmVal` with `destSel` = 1 (register).
- R6: An even opcode works at 8 bits. An odd opcode works at 32 bits when `opSize` = 1 and at 16 bits when `opSize` = 0. Operand bits above the width are ignored, and `result` is zero above the width.
- R7: `cfFlag` is the carry out of the top bit of the selected width (unsigned overflow).
- R8: `ofFlag` is set when both operands have equal sign bits at the selected width and the sum's sign bit differs from them.
- R9: `sfFlag` equals the top bit of the sum at the selected width. `zfFlag` is set when every bit of the truncated sum is zero.
- R10: `afFlag` is the carry from bit 3 into bit 4, i.e. bit 4 of destination XOR source XOR sum.
- R11: `pfFlag` is set when the low 8 bits of the sum hold an even number of ones.
- R12: Any opcode outside the eight add forms, or 0x80/0x81/0x83 with a nonzero `modrmReg`, gives `invalidOp` = 1 and `resValid` = 0 after the edge. In that case `result`, `destSel` and the flags keep their previous values.
- R13: Outputs update on the first rising edge at which `start` is high. At an edge with `start` low, `resValid` and `invalidOp` go to 0 and `result`, `destSel` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept the presented operation at this edge |
| opcode | input | 8 | Opcode byte |
| modrmReg | input | 3 | Reg field of the addressing byte |
| opSize | input | 1 | 1 = 32-bit, 0 = 16-bit for odd opcodes |
| regVal | input | 32 | Register operand (accumulator for 0x04/0x05) |
| rmVal | input | 32 | Register-or-memory operand value |
| immVal | input | 32 | Immediate field, low bits used per width |
| resValid | output | 1 | Registered result is from an accepted add |
| invalidOp | output | 1 | Last started operation was not an accepted add |
| result | output | 32 | Sum truncated to the width, zero above it |
| destSel | output | 2 | Write-back target: 0 r/m, 1 register, 2 accumulator |
| cfFlag | output | 1 | Carry |
| pfFlag | output | 1 | Even parity of the low byte |
| afFlag | output | 1 | Half carry out of bit 3 |
| zfFlag | output | 1 | Zero result |
| sfFlag | output | 1 | Sign of result |
| ofFlag | output | 1 | Signed overflow |

## Verification
Two things can meet in one edge. One is a flag update from an accepted add. The other is the hold that an unaccepted opcode causes, which happens when a rejected operation is started directly after a valid one. The bench sweeps all 256 opcodes back to back, including 0x80/0x81/0x83 with every reg field, so valid and rejected starts alternate with no gap. After each rejected start it checks that the flags and the sum from the previous valid add are still on the outputs.

Within a single add, carry, half carry, zero and parity can all flip together when a sum wraps to zero. The full 8-bit operand sweep and the boundary values at 16 and 32 bits provoke this. Each flag is judged against arithmetic computed in the bench.

// File: rtl/addx_pkg.sv
package addx_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {W8 = 2'd0, W16 = 2'd1, W32 = 2'd2} width_e;
  typedef enum logic [1:0] {SRC_REG = 2'd0, SRC_RM = 2'd1, SRC_IMM = 2'd2, SRC_IMM8SX = 2'd3} src_e;
  typedef enum logic [SEL_W-1:0] {DST_RM = 2'd0, DST_REG = 2'd1, DST_ACC = 2'd2} dsel_e;

  typedef struct packed {
    logic   load;
    logic   bad;
    logic   destIsRm;
    src_e   srcKind;
    width_e width;
    dsel_e  destSel;
  } ctrl_t;

  typedef struct packed {
    logic ofB;
    logic sfB;
    logic zfB;
    logic afB;
    logic pfB;
    logic cfB;
  } flags_t;
endpackage

// File: rtl/addx_ctrl.sv
module addx_ctrl
  import addx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [2:0]  modrmReg,
  input  logic        opSize,
  output ctrl_t       ctl
);
  logic   legal;
  width_e wideW;

  always_comb begin
    wideW = opSize ? W32 : W16;
    legal = 1'b1;
    ctl.destIsRm = 1'b1;
    ctl.srcKind  = SRC_REG;
    ctl.width    = W8;
    ctl.destSel  = DST_RM;
    case (opcode)
      8'h00, 8'h01: begin
        ctl.destIsRm = 1'b1;
        ctl.srcKind  = SRC_REG;
        ctl.destSel  = DST_RM;
      end
      8'h02, 8'h03: begin
        ctl.destIsRm = 1'b0;
        ctl.srcKind  = SRC_RM;
        ctl.destSel  = DST_REG;
      end
      8'h04, 8'h05: begin
        ctl.destIsRm = 1'b0;
        ctl.srcKind  = SRC_IMM;
        ctl.destSel  = DST_ACC;
      end
      8'h80, 8'h81: begin
        legal        = (modrmReg == 3'd0);
        ctl.srcKind  = SRC_IMM;
      end
      8'h83: begin
        legal        = (modrmReg == 3'd0);
        ctl.srcKind  = SRC_IMM8SX;
      end
      default: legal = 1'b0;
    endcase
    if (opcode[0]) ctl.width = wideW;
    ctl.load = start & legal;
    ctl.bad  = start & ~legal;
  end

  // R6
  even_width_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !opcode[0]) |-> (ctl.width == W8));

  // R12
  reg_field_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (opcode == 8'h81) && (modrmReg != 3'd0)) |-> (ctl.bad && !ctl.load));

  // R4
  sext_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && (opcode == 8'h83)) |-> (ctl.srcKind == SRC_IMM8SX && ctl.width != W8));
endmodule

// File: rtl/addx_datapath.sv
module addx_datapath
  import addx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] immVal,
  output logic              resValid,
  output logic              invalidOp,
  output logic [DATA_W-1:0] result,
  output logic [SEL_W-1:0]  destSel,
  output flags_t            flags
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] destRaw, srcRaw, mask, dOp, sOp, sum, xorV;
  logic [DATA_W:0]   wideSum;
  logic [IDX_W-1:0]  signIdx;
  logic [CIDX_W-1:0] carryIdx;
  flags_t            nextFlags;

  always_comb begin
    destRaw = ctl.destIsRm ? rmVal : regVal;
    case (ctl.srcKind)
      SRC_REG:    srcRaw = regVal;
      SRC_RM:     srcRaw = rmVal;
      SRC_IMM:    srcRaw = immVal;
      default:    srcRaw = {{(DATA_W-BYTE_W){immVal[BYTE_W-1]}}, immVal[BYTE_W-1:0]};
    endcase
    case (ctl.width)
      W8: begin
        mask     = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        signIdx  = IDX_W'(BYTE_W - 1);
        carryIdx = CIDX_W'(BYTE_W);
      end
      W16: begin
        mask     = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        signIdx  = IDX_W'(HALF_W - 1);
        carryIdx = CIDX_W'(HALF_W);
      end
      default: begin
        mask     = {DATA_W{1'b1}};
        signIdx  = IDX_W'(DATA_W - 1);
        carryIdx = CIDX_W'(DATA_W);
      end
    endcase
    dOp     = destRaw & mask;
    sOp     = srcRaw & mask;
    wideSum = {1'b0, dOp} + {1'b0, sOp};
    sum     = wideSum[DATA_W-1:0] & mask;
    xorV    = dOp ^ sOp ^ sum;
    nextFlags.cfB = wideSum[carryIdx];
    nextFlags.sfB = sum[signIdx];
    nextFlags.ofB = (dOp[signIdx] == sOp[signIdx]) && (sum[signIdx] != dOp[signIdx]);
    nextFlags.zfB = (sum == '0);
    nextFlags.afB = xorV[4];
    nextFlags.pfB = ~^sum[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      invalidOp <= 1'b0;
      result    <= '0;
      destSel   <= '0;
      flags     <= '0;
    end else begin
      resValid  <= ctl.load;
      invalidOp <= ctl.bad;
      if (ctl.load) begin
        result  <= sum;
        destSel <= ctl.destSel;
        flags   <= nextFlags;
      end
    end
  end

  // R9
  zf_result_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (flags.zfB == (result == '0)));

  // R11
  pf_result_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (flags.pfB == ~^result[BYTE_W-1:0]));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    invalidOp |-> ($stable(flags) && $stable(result) && !resValid));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!resValid && !invalidOp) |-> ($stable(result) && $stable(destSel)));
endmodule

// File: rtl/addx_unit.sv
module addx_unit
  import addx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [2:0]  modrmReg,
  input  logic        opSize,
  input  logic [31:0] regVal,
  input  logic [31:0] rmVal,
  input  logic [31:0] immVal,
  output logic        resValid,
  output logic        invalidOp,
  output logic [31:0] result,
  output logic [1:0]  destSel,
  output logic        cfFlag,
  output logic        pfFlag,
  output logic        afFlag,
  output logic        zfFlag,
  output logic        sfFlag,
  output logic        ofFlag
);
  ctrl_t  ctl;
  flags_t flagsQ;

  addx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .modrmReg (modrmReg),
    .opSize   (opSize),
    .ctl      (ctl)
  );

  addx_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .regVal    (regVal),
    .rmVal     (rmVal),
    .immVal    (immVal),
    .resValid  (resValid),
    .invalidOp (invalidOp),
    .result    (result),
    .destSel   (destSel),
    .flags     (flagsQ)
  );

  assign cfFlag = flagsQ.cfB;
  assign pfFlag = flagsQ.pfB;
  assign afFlag = flagsQ.afB;
  assign zfFlag = flagsQ.zfB;
  assign sfFlag = flagsQ.sfB;
  assign ofFlag = flagsQ.ofB;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && !invalidOp && result == '0));

  // R12
  out_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(resValid && invalidOp));
endmodule

// File: tb/sim_addx_unit.sv
module sim_addx_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [7:0]  opcode;
  logic [2:0]  modrmReg;
  logic        opSize;
  logic [31:0] regVal, rmVal, immVal;
  logic        resValid, invalidOp;
  logic [31:0] result;
  logic [1:0]  destSel;
  logic        cfFlag, pfFlag, afFlag, zfFlag, sfFlag, ofFlag;

  int nChecks = 0;
  int nFails  = 0;

  logic [5:0]  expFlags = '0;
  logic [31:0] expRes   = '0;
  logic [1:0]  expSel   = '0;

  always #5 clk = ~clk;

  addx_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .modrmReg(modrmReg),
    .opSize(opSize), .regVal(regVal), .rmVal(rmVal), .immVal(immVal),
    .resValid(resValid), .invalidOp(invalidOp), .result(result), .destSel(destSel),
    .cfFlag(cfFlag), .pfFlag(pfFlag), .afFlag(afFlag), .zfFlag(zfFlag),
    .sfFlag(sfFlag), .ofFlag(ofFlag)
  );

  function automatic logic [41:0] packOut();
    return {resValid, invalidOp, result, destSel, ofFlag, sfFlag, zfFlag, afFlag, pfFlag, cfFlag};
  endfunction

  task automatic compare(input logic [41:0] expv, input string tag);
    logic [41:0] act;
    act = packOut();
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s op=%h actual=%h expected=%h", tag, opcode, act, expv);
    end
  endtask

  // Drive one operation at a falling edge, check at the next falling edge.
  task automatic runOp(input logic [7:0] op, input logic [2:0] rf, input logic sz,
                       input logic [31:0] rv, input logic [31:0] mv, input logic [31:0] iv,
                       input string tag);
    int bits;
    logic legal;
    logic [31:0] mask, d, s, r;
    logic [32:0] full;
    logic [1:0] sel;
    logic cf, sf, of, zf, af, pf;
    bits  = (!op[0]) ? 8 : (sz ? 32 : 16);
    mask  = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    legal = 1'b1;
    d = '0; s = '0; sel = 2'd0;
    case (op)
      8'h00, 8'h01: begin d = mv; s = rv; sel = 2'd0; end
      8'h02, 8'h03: begin d = rv; s = mv; sel = 2'd1; end
      8'h04, 8'h05: begin d = rv; s = iv; sel = 2'd2; end
      8'h80, 8'h81: begin legal = (rf == 3'd0); d = mv; s = iv; sel = 2'd0; end
      8'h83:        begin legal = (rf == 3'd0); d = mv; s = {{24{iv[7]}}, iv[7:0]}; sel = 2'd0; end
      default:      legal = 1'b0;
    endcase
    d = d & mask;
    s = s & mask;
    full = {1'b0, d} + {1'b0, s};
    r  = full[31:0] & mask;
    cf = full[bits];
    sf = r[bits-1];
    of = (d[bits-1] == s[bits-1]) && (r[bits-1] != d[bits-1]);
    zf = (r == 32'd0);
    af = ((d ^ s ^ r) >> 4) & 32'd1 ? 1'b1 : 1'b0;
    pf = ~^r[7:0];
    if (legal) begin
      expRes   = r;
      expSel   = sel;
      expFlags = {of, sf, zf, af, pf, cf};
    end
    opcode = op; modrmReg = rf; opSize = sz;
    regVal = rv; rmVal = mv; immVal = iv;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    compare({legal, ~legal, expRes, expSel, expFlags}, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b1; opcode = 8'h00; modrmReg = '0; opSize = 1'b0;
    regVal = 32'h1; rmVal = 32'h1; immVal = '0;
    repeat (3) @(negedge clk);
    // R1: reset dominates a pending start
    compare(42'd0, "R1");
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    compare(42'd0, "R1 after release");

    // R5 R7 R8 R9 R10 R11: full 8-bit sweep, r/m destination
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        runOp(8'h00, 3'd0, 1'b0, 32'hABCD_EF00 | b, 32'h1234_5600 | a, 32'h0, "R5 R7 R8 R9 R10 R11 op00");

    // R13: idle cycle holds outputs, clears the valid strobe
    @(negedge clk);
    compare({2'b00, expRes, expSel, expFlags}, "R13 idle hold");

    // R6 boundary values at 16 and 32 bits
    runOp(8'h01, 3'd0, 1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0, "R6 R7 wrap32");
    runOp(8'h01, 3'd0, 1'b1, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0, "R6 R8 ovf32");
    runOp(8'h01, 3'd0, 1'b0, 32'h8000_8000, 32'hFFFF_8000, 32'h0, "R6 R8 ovf16");
    runOp(8'h03, 3'd0, 1'b0, 32'h1234_0001, 32'h5678_FFFF, 32'h0, "R6 R9 zero16");
    runOp(8'h03, 3'd0, 1'b1, 32'h0000_000F, 32'h0000_0001, 32'h0, "R6 R10 half32");

    // R5 R6: register-destination and wide forms
    for (int k = 0; k < 1500; k++) begin
      runOp(8'h01, 3'd0, k[0], $urandom, $urandom, $urandom, "R5 R6 op01");
      runOp(8'h02, 3'd0, k[0], $urandom, $urandom, $urandom, "R5 R6 op02");
      runOp(8'h03, 3'd0, k[1], $urandom, $urandom, $urandom, "R5 R6 op03");
    end

    // R2: accumulator forms
    for (int k = 0; k < 800; k++) begin
      runOp(8'h04, $urandom, k[0], $urandom, $urandom, $urandom, "R2 op04");
      runOp(8'h05, 3'd0, k[0], $urandom, $urandom, $urandom, "R2 op05");
    end

    // R3 R4: immediate to r/m, including sign-extension corners
    for (int k = 0; k < 800; k++) begin
      runOp(8'h80, 3'd0, k[0], $urandom, $urandom, $urandom, "R3 op80");
      runOp(8'h81, 3'd0, k[0], $urandom, $urandom, $urandom, "R3 op81");
      runOp(8'h83, 3'd0, k[0], $urandom, $urandom, $urandom, "R4 op83");
    end
    runOp(8'h83, 3'd0, 1'b1, 32'h0, 32'h0000_0001, 32'h0000_00FF, "R4 minus one32");
    runOp(8'h83, 3'd0, 1'b0, 32'h0, 32'h0000_0000, 32'hFFFF_FF80, "R4 neg16");
    runOp(8'h83, 3'd0, 1'b1, 32'h0, 32'h7FFF_FF90, 32'h0000_007F, "R4 pos32");

    // R12: every opcode back to back, and every reg field on the group forms
    for (int op = 0; op < 256; op++)
      runOp(op[7:0], op[2:0], op[3], $urandom, $urandom, $urandom, "R12 opcode sweep");
    for (int g = 0; g < 3; g++)
      for (int rf = 0; rf < 8; rf++) begin
        runOp(8'h01, 3'd0, 1'b1, $urandom, $urandom, 32'h0, "R12 prime");
        runOp((g == 0) ? 8'h80 : (g == 1) ? 8'h81 : 8'h83, rf[2:0], 1'b1,
              $urandom, $urandom, $urandom, "R12 reg field");
      end

    @(negedge clk);
    compare({2'b00, expRes, expSel, expFlags}, "R13 final idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule